// File: doc/BRIEF.md
# Descriptor ring queue manager

This block handles one host-memory descriptor ring for a software-driven network interface. The ring can serve either transmit or receive. Software sets it up through a write-only window of four 32-bit registers: a control word, a producer-index doorbell, and the low and high halves of the 64-bit ring base address. The block keeps its own 16-bit consumer index.

While the ring is enabled and the consumer index differs from the producer index, the block works out the host address of the next 16-byte entry and issues a single read request for it. It waits for the 128-bit response and splits it into a buffer length and a buffer pointer. It then offers the pair on a valid/ready output. The consumer index moves on only when that output is accepted. The ring size is a power of two, set by a clamped log-size field in the control word.

The memory read is a plain request/response pair. At most one read is in flight at any time.

Top module: `desc_ring_mgr`

## Requirements
- R1: After reset, `rd_req_valid_o` and `desc_valid_o` are low.
- R2: While the enable bit (control bit 0) is clear, no read request is issued, whatever value the doorbell holds.
- R3: While the consumer index equals the producer index (bits 15:0 of a doorbell write at byte offset 0x4), no read request is issued.
- R4: The request address is the 64-bit base (low half at offset 0x8, high half at offset 0xC) plus 16 times (consumer index AND (ring size - 1)).
- R5: The log2 ring size is control bits 20:16. A value below 4 is treated as 4, and a value above 15 is treated as 15.
- R6: At most one read is in flight. No new request is raised from the time a request is accepted until the resulting descriptor is taken.
- R7: From the response word, the length is bits 63:32 and the buffer address is bits 127:64. Bits 31:0 are ignored.
- R8: A presented descriptor holds its valid, length and address stable until `desc_ready_i`. The consumer index advances by one only on that handshake.
- R9: Writing control (offset 0x0) with bit 0 clear resets the consumer index to zero. After re-enabling, fetching resumes from slot 0.
- R10: A raised request holds its valid and address stable until `rd_req_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| rd_req_valid_o | output | 1 | Descriptor read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | 64 | Host address of the descriptor |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 128 | Descriptor contents, little-endian |
| desc_valid_o | output | 1 | Parsed descriptor valid |
| desc_ready_i | input | 1 | Parsed descriptor accepted |
| desc_len_o | output | 32 | Buffer length |
| desc_addr_o | output | 64 | Buffer address |

## Verification
The assertions assume the memory side returns exactly one response for each accepted request, and never returns one unprompted. They also assume a request can be withdrawn only by a control write that clears the enable bit. The bench acts as that memory. It raises the response only after it has accepted a request, with a latency of zero to two idle cycles, and it drops the enable only while the ring is idle. The sweep covers several log-size settings, including both clamped ends, over more entries than the smallest ring holds, so that slot wrap-around is checked against arithmetic expectations.

// File: rtl/drm_pkg.sv
package drm_pkg;
  localparam int unsigned IDX_W   = 16;
  localparam int unsigned AW      = 64;
  localparam int unsigned DW      = 128;
  localparam int unsigned LOG_W   = 5;
  localparam int unsigned LOG_MIN = 4;
  localparam int unsigned LOG_MAX = 15;

  // word index = reg_addr[3:2]
  localparam logic [1:0] OFS_CTRL  = 2'd0;
  localparam logic [1:0] OFS_DBELL = 2'd1;
  localparam logic [1:0] OFS_BASEL = 2'd2;
  localparam logic [1:0] OFS_BASEH = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_OUT
  } fetch_state_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [31:0]   len;
  } desc_t;
endpackage

// File: rtl/drm_regs.sv
module drm_regs
  import drm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic             en_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] mask_o,
  output logic [IDX_W-1:0] prod_o,
  output logic [AW-1:0]    base_o
);
  logic             en_q;
  logic [LOG_W-1:0] log_q;
  logic [IDX_W-1:0] prod_q;
  logic [AW-1:0]    base_q;
  logic [LOG_W-1:0] log_eff;
  logic [1:0]       widx;

  assign widx  = addr_i[3:2];
  assign clr_o = we_i && (widx == OFS_CTRL) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      log_q  <= LOG_W'(LOG_MIN);
      prod_q <= '0;
      base_q <= '0;
    end else if (we_i) begin
      case (widx)
        OFS_CTRL: begin
          en_q  <= wdata_i[0];
          log_q <= wdata_i[16 +: LOG_W];
        end
        OFS_DBELL: prod_q <= wdata_i[IDX_W-1:0];
        OFS_BASEL: base_q[31:0] <= wdata_i;
        default:   base_q[AW-1:32] <= wdata_i;
      endcase
    end
  end

  always_comb begin
    if (log_q < LOG_W'(LOG_MIN))      log_eff = LOG_W'(LOG_MIN);
    else if (log_q > LOG_W'(LOG_MAX)) log_eff = LOG_W'(LOG_MAX);
    else                              log_eff = log_q;
  end

  assign mask_o = IDX_W'((32'd1 << log_eff) - 32'd1);
  assign en_o   = en_q;
  assign prod_o = prod_q;
  assign base_o = base_q;
endmodule

// File: rtl/drm_parse.sv
module drm_parse
  import drm_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output desc_t         desc_o
);
  // bytes 0..3 reserved, 4..7 length, 8..15 address
  assign desc_o.len  = data_i[63:32];
  assign desc_o.addr = data_i[DW-1:64];
endmodule

// File: rtl/drm_fetch.sv
module drm_fetch
  import drm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] mask_i,
  input  logic [IDX_W-1:0] prod_i,
  input  logic [AW-1:0]    base_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [AW-1:0]    req_addr_o,
  input  logic             rsp_valid_i,
  input  desc_t            rsp_desc_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output desc_t            out_desc_o,
  output logic [IDX_W-1:0] cons_o
);
  fetch_state_e     state_q;
  logic [IDX_W-1:0] cons_q;
  logic [AW-1:0]    addr_q;
  desc_t            desc_q;
  logic             drop_q;
  logic [IDX_W-1:0] slot;

  assign slot = cons_q & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cons_q  <= '0;
      addr_q  <= '0;
      desc_q  <= '0;
      drop_q  <= 1'b0;
    end else if (clr_i) begin
      cons_q <= '0;
      // an in-flight read must still drain its response
      if (state_q == ST_WAIT && !rsp_valid_i) drop_q <= 1'b1;
      else begin
        state_q <= ST_IDLE;
        drop_q  <= 1'b0;
      end
    end else begin
      case (state_q)
        ST_IDLE: if (en_i && cons_q != prod_i) begin
          addr_q  <= base_i + AW'({slot, 4'b0000});
          state_q <= ST_REQ;
        end
        ST_REQ: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (drop_q) begin
            drop_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            desc_q  <= rsp_desc_i;
            state_q <= ST_OUT;
          end
        end
        default: if (out_ready_i) begin
          cons_q  <= cons_q + 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign req_addr_o  = addr_q;
  assign out_valid_o = (state_q == ST_OUT);
  assign out_desc_o  = desc_q;
  assign cons_o      = cons_q;
endmodule

// File: rtl/desc_ring_mgr.sv
module desc_ring_mgr
  import drm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic          rd_req_valid_o,
  input  logic          rd_req_ready_i,
  output logic [63:0]   rd_req_addr_o,
  input  logic          rd_rsp_valid_i,
  input  logic [127:0]  rd_rsp_data_i,
  output logic          desc_valid_o,
  input  logic          desc_ready_i,
  output logic [31:0]   desc_len_o,
  output logic [63:0]   desc_addr_o
);
  logic             ctrl_en;
  logic             clr;
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] prod;
  logic [IDX_W-1:0] cons;
  logic [AW-1:0]    base;
  desc_t            rsp_desc;
  desc_t            out_desc;

  drm_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .en_o    (ctrl_en),
    .clr_o   (clr),
    .mask_o  (mask),
    .prod_o  (prod),
    .base_o  (base)
  );

  drm_parse u_parse (
    .data_i (rd_rsp_data_i),
    .desc_o (rsp_desc)
  );

  drm_fetch u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_en),
    .clr_i       (clr),
    .mask_i      (mask),
    .prod_i      (prod),
    .base_i      (base),
    .req_valid_o (rd_req_valid_o),
    .req_ready_i (rd_req_ready_i),
    .req_addr_o  (rd_req_addr_o),
    .rsp_valid_i (rd_rsp_valid_i),
    .rsp_desc_i  (rsp_desc),
    .out_valid_o (desc_valid_o),
    .out_ready_i (desc_ready_i),
    .out_desc_o  (out_desc),
    .cons_o      (cons)
  );

  assign desc_len_o  = out_desc.len;
  assign desc_addr_o = out_desc.addr;
endmodule

// File: rtl/drm_checker.sv
module drm_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_req_valid_o,
  input logic        rd_req_ready_i,
  input logic [63:0] rd_req_addr_o,
  input logic        desc_valid_o,
  input logic        desc_ready_i,
  input logic [31:0] desc_len_o,
  input logic [63:0] desc_addr_o,
  input logic        clr,
  input logic        ctrl_en,
  input logic [15:0] cons,
  input logic [15:0] prod
);
  a_r2_no_fetch_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en |-> !rd_req_valid_o);

  a_r3_no_fetch_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_valid_o) |-> $past(cons != prod));

  a_r4_entry_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o |-> rd_req_addr_o[3:0] == 4'h0);

  a_r6_single_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_valid_o, desc_valid_o}));

  a_r6_no_req_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && rd_req_ready_i |=> !rd_req_valid_o);

  a_r8_desc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i && !clr |=>
      desc_valid_o && $stable(desc_len_o) && $stable(desc_addr_o));

  a_r8_cons_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr && !(desc_valid_o && desc_ready_i) |=> $stable(cons));

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i && !clr |=>
      rd_req_valid_o && $stable(rd_req_addr_o));
endmodule

bind desc_ring_mgr drm_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_addr_o  (rd_req_addr_o),
  .desc_valid_o   (desc_valid_o),
  .desc_ready_i   (desc_ready_i),
  .desc_len_o     (desc_len_o),
  .desc_addr_o    (desc_addr_o),
  .clr            (clr),
  .ctrl_en        (ctrl_en),
  .cons           (cons),
  .prod           (prod)
);

// File: tb/desc_ring_mgr_bench.sv
`timescale 1ns/1ps
module desc_ring_mgr_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         reg_we_i = 1'b0;
  logic [3:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic         rd_req_valid_o;
  logic         rd_req_ready_i = 1'b0;
  logic [63:0]  rd_req_addr_o;
  logic         rd_rsp_valid_i = 1'b0;
  logic [127:0] rd_rsp_data_i = '0;
  logic         desc_valid_o;
  logic         desc_ready_i = 1'b0;
  logic [31:0]  desc_len_o;
  logic [63:0]  desc_addr_o;

  int checks = 0;
  int errors = 0;
  localparam logic [63:0] BASE = 64'h0000_00AB_C000_0100;

  always #5 clk_i = ~clk_i;

  desc_ring_mgr u_desc_ring_mgr (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // watch n cycles: no request may appear
  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (rd_req_valid_o) seen = 1'b1;
    end
    chk(!seen, req, 64'(seen), 64'd0);
  endtask

  function automatic logic [15:0] mask_of(input int lg);
    int e = (lg < 4) ? 4 : (lg > 15) ? 15 : lg;
    return 16'((1 << e) - 1);
  endfunction

  // serve one fetch as the memory, then take the descriptor
  task automatic serve(input int k, input logic [63:0] exp_addr, input int lat, input bit hold);
    int t = 0;
    logic [31:0] len_e = 32'h100 + 32'(k);
    logic [63:0] ptr_e = 64'hFEED_0000_0000_0000 | 64'(k);
    @(negedge clk_i);
    while (!rd_req_valid_o && t < 50) begin
      @(negedge clk_i); t++;
    end
    chk(rd_req_valid_o, "R3 request expected", 64'(rd_req_valid_o), 64'd1);
    chk(rd_req_addr_o == exp_addr, "R4/R5 fetch address", rd_req_addr_o, exp_addr);
    if (hold) begin
      @(negedge clk_i);
      chk(rd_req_valid_o && rd_req_addr_o == exp_addr, "R10 request held",
          rd_req_addr_o, exp_addr);
    end
    rd_req_ready_i = 1'b1;
    @(negedge clk_i);
    rd_req_ready_i = 1'b0;
    for (int i = 0; i < lat; i++) begin
      chk(!rd_req_valid_o && !desc_valid_o, "R6 idle while in flight",
          64'({rd_req_valid_o, desc_valid_o}), 64'd0);
      @(negedge clk_i);
    end
    rd_rsp_valid_i = 1'b1;
    rd_rsp_data_i  = {ptr_e, len_e, 32'hDEAD_BEEF};
    @(negedge clk_i);
    rd_rsp_valid_i = 1'b0;
    rd_rsp_data_i  = '0;
    chk(desc_valid_o, "R7 descriptor valid", 64'(desc_valid_o), 64'd1);
    chk(desc_len_o == len_e, "R7 length field", 64'(desc_len_o), 64'(len_e));
    chk(desc_addr_o == ptr_e, "R7 address field", desc_addr_o, ptr_e);
    if (hold) begin
      repeat (2) @(negedge clk_i);
      chk(desc_valid_o && desc_len_o == len_e && desc_addr_o == ptr_e && !rd_req_valid_o,
          "R8 descriptor held", desc_addr_o, ptr_e);
    end
    desc_ready_i = 1'b1;
    @(negedge clk_i);
    desc_ready_i = 1'b0;
  endtask

  task automatic ring_setup(input int lg, input int prod);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0);
    wr(4'h8, BASE[31:0]);
    wr(4'hC, BASE[63:32]);
    wr(4'h0, 32'h1 | (32'(lg) << 16));
    wr(4'h4, 32'(prod));
  endtask

  initial begin
    int lgs[4] = '{1, 4, 6, 20};
    repeat (3) @(negedge clk_i);
    chk(!rd_req_valid_o && !desc_valid_o, "R1 reset outputs",
        64'({rd_req_valid_o, desc_valid_o}), 64'd0);
    rst_ni = 1'b1;

    // R2: doorbell rung while disabled
    wr(4'h8, BASE[31:0]);
    wr(4'hC, BASE[63:32]);
    wr(4'h4, 32'd5);
    quiet(12, "R2 no fetch when disabled");

    // R3: enabled but empty
    ring_setup(4, 0);
    quiet(12, "R3 no fetch when empty");

    // sweep of log sizes with slot wrap
    foreach (lgs[j]) begin
      ring_setup(lgs[j], 40);
      for (int k = 0; k < 40; k++)
        serve(k, BASE + 64'((k & int'(mask_of(lgs[j]))) * 16), k % 3, (k % 4) == 0);
      quiet(8, "R3 stop at producer");
    end

    // R8: one doorbell step at a time, consumer moves by one
    ring_setup(5, 1);
    serve(0, BASE, 1, 1'b1);
    quiet(6, "R8 single advance");
    wr(4'h4, 32'd2);
    serve(1, BASE + 64'd16, 0, 1'b0);
    quiet(6, "R8 single advance");

    // R9: disable clears consumer, refetch starts at slot 0
    ring_setup(4, 3);
    for (int k = 0; k < 3; k++) serve(k, BASE + 64'(k * 16), 1, 1'b0);
    wr(4'h0, 32'h0);
    wr(4'h0, 32'h1 | (32'd4 << 16));
    serve(0, BASE, 0, 1'b0);
    serve(1, BASE + 64'd16, 0, 1'b0);
    serve(2, BASE + 64'd32, 0, 1'b0);
    quiet(6, "R9 stops at producer after restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule